// File: doc/BRIEF.md
# Three-Channel Majority Voter with Channel Health Tracking

The voter sits behind three lockstep computing channels that work on the same inputs. Each channel delivers a result word with its own valid strobe. In a cycle where the results belong to the same step, the voter forwards the value most channels agree on. A channel that disagrees with that value is marked faulty. The fault mark stays set until a clear is asserted, and a marked channel takes no part in later votes. Once a channel is marked, the block keeps running on the two remaining channels, which must match exactly for a result to go out.

The block has health state; it is more than a bitwise 2-of-3 gate. A vote without a majority raises an alarm and marks no channel. If the strobes of the active channels do not line up, the results come from different steps and are never voted together; the block reports a synchronization error instead. Every result appears on the outputs one clock after the inputs are sampled.

Top module: `tmr_voter`

## Requirements
- R1: When all three channels are active, every strobe is high and all words are equal, `vote_valid_o` is high one cycle later, `vote_data_o` carries the common word and no fault flag changes.
- R2: When all three channels are active and valid, two words match and the third differs, the matching word is output with `vote_valid_o` one cycle later. In the same cycle, `fault_o[k]` rises for the differing channel k, where bit k belongs to channel k of `ch_data_i`.
- R3: A set fault flag stays set until `clear_i` is sampled high. A high `clear_i` clears all three flags one cycle later and produces no output, alarm or sync error in that cycle.
- R4: A channel whose flag is set is excluded from votes. With two active channels that are both valid and agree, their word is output whatever the excluded channel drives on its data or strobe.
- R5: With two active channels that are both valid but disagree, `no_major_o` is high one cycle later, `vote_valid_o` is low and no fault flag changes.
- R6: With three active, valid channels whose words all differ pairwise, `no_major_o` is high one cycle later, `vote_valid_o` is low and the fault flags are unchanged.
- R7: If any strobe is high but the strobes of the active channels are not all high, `sync_err_o` is high one cycle later. `vote_valid_o` and `no_major_o` are low and the fault flags are unchanged.
- R8: While `rst_ni` is low, all outputs are low and every fault flag is clear.
- R9: In a cycle with no strobe high, all three status outputs are low one cycle later and the flags do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ch_data_i | input | 3 x DATA_W | Result words, index k is channel k |
| ch_valid_i | input | 3 | Per-channel result strobe |
| clear_i | input | 1 | Clears all channel fault flags |
| vote_data_o | output | DATA_W | Voted result word |
| vote_valid_o | output | 1 | Voted word is valid |
| no_major_o | output | 1 | A vote found no agreement |
| sync_err_o | output | 1 | Active channels' strobes were misaligned |
| fault_o | output | 3 | Sticky per-channel fault flags |

## Verification
The stimulus applies unanimous words with several distinct values. These show that the output tracks the data and is not a fixed selection. Single-channel divergences are used to tell which channel gets marked and which copy is forwarded. Fully disjoint words are used to separate the no-majority case from a 2-of-3 case. After one channel is marked, the bench drives that channel with garbage data and with a lone strobe, which shows whether it is truly excluded. It then drives disagreeing survivors and half-aligned strobes to separate the alarm from the sync error. A clear followed by a divergence on a different channel shows that the health state is rebuilt from scratch.

// File: rtl/tmr_voter_pkg.sv
package tmr_voter_pkg;
  localparam int unsigned NUM_CH = 3;
  localparam int unsigned SEL_W  = 2;

  typedef enum logic [1:0] {
    ACT_IDLE  = 2'd0,
    ACT_VOTE  = 2'd1,
    ACT_ALARM = 2'd2,
    ACT_SYNC  = 2'd3
  } vote_act_e;
endpackage

// File: rtl/tmr_pair_cmp.sv
// eq_o[0]: ch0==ch1, eq_o[1]: ch0==ch2, eq_o[2]: ch1==ch2
module tmr_pair_cmp
  import tmr_voter_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [NUM_CH-1:0][DATA_W-1:0] data_i,
  output logic [NUM_CH-1:0]             eq_o
);
  for (genvar k = 0; k < NUM_CH; k++) begin : g_pair
    localparam int unsigned IdxA = (k == 2) ? 1 : 0;
    localparam int unsigned IdxB = (k == 0) ? 1 : 2;
    assign eq_o[k] = (data_i[IdxA] == data_i[IdxB]);
  end
endmodule

// File: rtl/tmr_decide.sv
module tmr_decide
  import tmr_voter_pkg::*;
(
  input  logic [NUM_CH-1:0] eq_i,
  input  logic [NUM_CH-1:0] valid_i,
  input  logic [NUM_CH-1:0] active_i,
  output vote_act_e         act_o,
  output logic [SEL_W-1:0]  sel_o,
  output logic [NUM_CH-1:0] flag_o
);
  logic [1:0] n_act;
  logic       pair_eq;

  assign n_act = 2'($countones(active_i));

  always_comb begin
    unique case (active_i)
      3'b011:  pair_eq = eq_i[0];
      3'b101:  pair_eq = eq_i[1];
      3'b110:  pair_eq = eq_i[2];
      default: pair_eq = 1'b0;
    endcase
  end

  always_comb begin
    act_o  = ACT_IDLE;
    sel_o  = '0;
    flag_o = '0;
    if (!(|valid_i)) begin
      act_o = ACT_IDLE;
    end else if (n_act < 2'd2) begin
      act_o = ACT_ALARM;
    end else if ((valid_i & active_i) != active_i) begin
      act_o = ACT_SYNC;
    end else if (n_act == 2'd3) begin
      if (eq_i[0]) begin
        act_o     = ACT_VOTE;
        sel_o     = 2'd0;
        flag_o[2] = ~eq_i[1];
      end else if (eq_i[1]) begin
        act_o     = ACT_VOTE;
        sel_o     = 2'd0;
        flag_o[1] = 1'b1;
      end else if (eq_i[2]) begin
        act_o     = ACT_VOTE;
        sel_o     = 2'd1;
        flag_o[0] = 1'b1;
      end else begin
        act_o = ACT_ALARM;
      end
    end else begin
      act_o = pair_eq ? ACT_VOTE : ACT_ALARM;
      sel_o = active_i[0] ? 2'd0 : 2'd1;
    end
  end
endmodule

// File: rtl/tmr_health.sv
module tmr_health
  import tmr_voter_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic [NUM_CH-1:0] set_i,
  output logic [NUM_CH-1:0] fault_o
);
  logic [NUM_CH-1:0] fault_q;

  for (genvar k = 0; k < NUM_CH; k++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       fault_q[k] <= 1'b0;
      else if (clear_i)  fault_q[k] <= 1'b0;
      else if (set_i[k]) fault_q[k] <= 1'b1;
    end

    assert_flag_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fault_q[k] && !clear_i) |=> fault_q[k]);
    assert_clear_drops_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clear_i |=> !fault_q[k]);
  end

  assign fault_o = fault_q;
endmodule

// File: rtl/tmr_voter.sv
module tmr_voter
  import tmr_voter_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NUM_CH-1:0][DATA_W-1:0] ch_data_i,
  input  logic [NUM_CH-1:0]             ch_valid_i,
  input  logic                          clear_i,
  output logic [DATA_W-1:0]             vote_data_o,
  output logic                          vote_valid_o,
  output logic                          no_major_o,
  output logic                          sync_err_o,
  output logic [NUM_CH-1:0]             fault_o
);
  logic [NUM_CH-1:0] eq;
  logic [NUM_CH-1:0] fault;
  logic [NUM_CH-1:0] flag_set;
  logic [NUM_CH-1:0] health_set;
  logic [SEL_W-1:0]  sel;
  vote_act_e         act;
  vote_act_e         act_eff;

  logic [DATA_W-1:0] data_q;
  logic              valid_q, alarm_q, sync_q;

  tmr_pair_cmp #(.DATA_W(DATA_W)) i_cmp (
    .data_i (ch_data_i),
    .eq_o   (eq)
  );

  tmr_decide i_decide (
    .eq_i     (eq),
    .valid_i  (ch_valid_i),
    .active_i (~fault),
    .act_o    (act),
    .sel_o    (sel),
    .flag_o   (flag_set)
  );

  // clear wins over any vote in the same cycle
  assign act_eff    = clear_i ? ACT_IDLE : act;
  assign health_set = clear_i ? '0 : flag_set;

  tmr_health i_health (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear_i),
    .set_i   (health_set),
    .fault_o (fault)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      valid_q <= 1'b0;
      alarm_q <= 1'b0;
      sync_q  <= 1'b0;
    end else begin
      valid_q <= (act_eff == ACT_VOTE);
      alarm_q <= (act_eff == ACT_ALARM);
      sync_q  <= (act_eff == ACT_SYNC);
      if (act_eff == ACT_VOTE) data_q <= ch_data_i[sel];
    end
  end

  assign vote_data_o  = data_q;
  assign vote_valid_o = valid_q;
  assign no_major_o   = alarm_q;
  assign sync_err_o   = sync_q;
  assign fault_o      = fault;

  assert_one_status_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({vote_valid_o, no_major_o, sync_err_o}));
  // R5 as well: a failed vote never touches health
  assert_alarm_keeps_flags_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (no_major_o || sync_err_o) |-> $stable(fault_o));
  assert_flag_needs_vote_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && |(flag_set & ~fault)) |=> vote_valid_o);
  assert_single_flag_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(flag_set) <= 1);
endmodule

// File: tb/test_tmr_voter.sv
module test_tmr_voter;
  localparam int unsigned W = 32;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic [2:0][W-1:0] ch_data_i = '0;
  logic [2:0]       ch_valid_i = '0;
  logic             clear_i = 1'b0;
  logic [W-1:0]     vote_data_o;
  logic             vote_valid_o, no_major_o, sync_err_o;
  logic [2:0]       fault_o;

  tmr_voter #(.DATA_W(W)) i_tmr_voter (
    .clk_i, .rst_ni, .ch_data_i, .ch_valid_i, .clear_i,
    .vote_data_o, .vote_valid_o, .no_major_o, .sync_err_o, .fault_o
  );

  always #5 clk_i = ~clk_i;

  int     n_vec = 0;
  int     n_bad = 0;
  int     cyc = 0;
  bit     done = 0;
  bit     mf[3];
  logic   e_valid = 0, e_alarm = 0, e_sync = 0;
  logic [W-1:0] e_data = '0;
  logic [2:0]   e_fault = '0;
  string  e_tag = "R8";

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 5000 && !done) begin
      n_bad++;
      $display("FAIL watchdog: run hung, got %0d cycles expected < 5000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  task automatic compare();
    n_vec++;
    if (vote_valid_o !== e_valid || no_major_o !== e_alarm || sync_err_o !== e_sync ||
        fault_o !== e_fault || (e_valid && vote_data_o !== e_data)) begin
      n_bad++;
      $display("FAIL %s: got v=%b a=%b s=%b f=%b d=%h expected v=%b a=%b s=%b f=%b d=%h",
               e_tag, vote_valid_o, no_major_o, sync_err_o, fault_o, vote_data_o,
               e_valid, e_alarm, e_sync, e_fault, e_data);
    end
  endtask

  // behavioural model: count agreeing active channels
  task automatic model(input logic [W-1:0] d[3], input logic [2:0] v, input logic clr);
    int nact = 0, nvld = 0, best = 0, bi = 0, odd = -1;
    e_valid = 0; e_alarm = 0; e_sync = 0;
    if (clr) begin
      foreach (mf[i]) mf[i] = 0;
    end else if (v != 3'b000) begin
      for (int i = 0; i < 3; i++) if (!mf[i]) begin
        nact++;
        if (v[i]) nvld++;
      end
      if (nact < 2) e_alarm = 1;
      else if (nvld != nact) e_sync = 1;
      else begin
        for (int i = 0; i < 3; i++) if (!mf[i]) begin
          int c = 0;
          for (int j = 0; j < 3; j++) if (!mf[j] && d[j] == d[i]) c++;
          if (c > best) begin best = c; bi = i; end
          if (c == 1) odd = i;
        end
        if (best >= 2) begin
          e_valid = 1;
          e_data  = d[bi];
          if (nact == 3 && best == 2) mf[odd] = 1;
        end else e_alarm = 1;
      end
    end
    e_fault = {mf[2], mf[1], mf[0]};
  endtask

  task automatic step(input logic [W-1:0] a, input logic [W-1:0] b, input logic [W-1:0] c,
                      input logic [2:0] v, input logic clr, input string tag);
    logic [W-1:0] d[3];
    @(negedge clk_i);
    compare();
    d[0] = a; d[1] = b; d[2] = c;
    ch_data_i = {c, b, a};
    ch_valid_i = v;
    clear_i = clr;
    model(d, v, clr);
    e_tag = tag;
  endtask

  initial begin
    foreach (mf[i]) mf[i] = 0;
    repeat (3) @(negedge clk_i);
    compare();                       // R8 reset state while held
    rst_ni = 1'b1;
    step('0, '0, '0, 3'b000, 0, "R9");
    step(32'h1, 32'h2, 32'h3, 3'b000, 0, "R9");
    // R1 unanimous, several values
    step(32'hDEADBEEF, 32'hDEADBEEF, 32'hDEADBEEF, 3'b111, 0, "R1");
    step(32'h00000000, 32'h00000000, 32'h00000000, 3'b111, 0, "R1");
    step(32'hA5A55A5A, 32'hA5A55A5A, 32'hA5A55A5A, 3'b111, 0, "R1");
    // R7 misaligned with three active
    step(32'h7, 32'h7, 32'h7, 3'b011, 0, "R7");
    step(32'h7, 32'h7, 32'h7, 3'b100, 0, "R7");
    // R6 all different
    step(32'h10, 32'h20, 32'h30, 3'b111, 0, "R6");
    // R2 ch2 diverges
    step(32'h55, 32'h55, 32'h66, 3'b111, 0, "R2");
    // R4 ch2 excluded: garbage data, missing strobe
    step(32'h77, 32'h77, 32'hFFFF, 3'b111, 0, "R4");
    step(32'h88, 32'h88, 32'h0, 3'b011, 0, "R4");
    // R7 lone strobe on excluded channel, then half aligned
    step(32'h88, 32'h88, 32'h88, 3'b100, 0, "R7");
    step(32'h99, 32'h99, 32'h99, 3'b001, 0, "R7");
    // R5 survivors disagree
    step(32'h1234, 32'h4321, 32'h1234, 3'b111, 0, "R5");
    step(32'h0, 32'h0, 32'h0, 3'b000, 0, "R3");   // flag still set
    // R3 clear wins over a divergent vote
    step(32'h1, 32'h2, 32'h2, 3'b111, 1, "R3");
    // R2 different channels now
    step(32'h3, 32'h4, 32'h4, 3'b111, 0, "R2");
    step(32'hC0, 32'hC0, 32'hC0, 3'b111, 0, "R4");
    step(32'hC1, 32'hC2, 32'hC2, 3'b110, 0, "R4");
    step(32'hC1, 32'hC3, 32'hC2, 3'b111, 0, "R5");
    step(32'h0, 32'h0, 32'h0, 3'b000, 1, "R3");
    step(32'h9, 32'h8, 32'h9, 3'b111, 0, "R2");
    step(32'hE, 32'hE, 32'hE, 3'b111, 0, "R4");
    step(32'h0, 32'h0, 32'h0, 3'b000, 0, "R9");
    @(negedge clk_i);
    compare();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule